// File: doc/BRIEF.md
# Prioritized Interrupt Controller Register File

This block gathers 64 level-sensitive interrupt sources behind a small memory-mapped register bus and presents one prioritized request to a processor. Each source has its own enable bit and a 4-bit priority. On every clock the block samples the source levels and masks them with the enables. It then picks the active source with the highest nonzero priority and drives a request, its level and its source number to the processor side.

Software changes enables without a read-modify-write. Ones written to a set address turn enables on, and ones written to a separate clear address turn them off. A single mode flag in a control word uses the same pair-of-addresses scheme. Priorities are packed eight 4-bit fields to a 32-bit word. The status words show the sampled levels and the masked requests, and software can read them at any time.

Top module: `irq_prio_regfile`

## Requirements
- R1: After reset every enable is clear, every priority field is zero, the mode flag is zero, the request output is low, and level and source number read zero.
- R2: A write to byte offset 0x00 with data bit 0 at one sets the mode flag. A write to offset 0x08 with data bit 0 at one clears it. A zero in bit 0 leaves the flag unchanged. The flag drives the `irl_mode_o` output.
- R3: Priority words sit at offsets 0x10 + 8*k for k = 0..7 and can be read and written. Source n takes its priority from word n/8, bits (n mod 8)*4 up to (n mod 8)*4+3.
- R4: Writing to offset 0x70 (sources 0–31, bit i = source i) or 0x78 (sources 32–63, bit i = source 32+i) sets the enables whose data bits are one and leaves the others alone. Reading these offsets returns the current enables of that half. A bus access whose byte address has nonzero bits [2:0] is ignored.
- R5: Writing to offset 0x80 (low half) or 0x88 (high half) clears the enables whose data bits are one. Writing all ones to both leaves every source masked, and the request output then stays low.
- R6: Offsets 0x50/0x58 read the sampled source levels for the low and high halves. Offsets 0x60/0x68 read the sampled levels ANDed with the enables. Writes to these four offsets change nothing. A pending source whose enable is clear is never reported.
- R7: A source whose priority is zero never raises the request, even when it is enabled and pending.
- R8: The reported level is the largest priority among active requests. On a tie the lowest source number wins. The request is high exactly when such a source exists, and level and source number are zero when the request is low.
- R9: Read data appears on `bus_rdata` one clock after the edge that samples `bus_rd`. Reads of offsets 0x00, 0x08, 0x80 and 0x88 return zero.
- R10: A change on the source inputs reaches the processor outputs on the second rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| src_lvl_i | input | 64 | Level of each interrupt source |
| irl_mode_o | output | 1 | Current state of the mode flag |
| cpu_irq_o | output | 1 | Interrupt request to the processor |
| cpu_lvl_o | output | 4 | Priority of the winning source |
| cpu_id_o | output | 6 | Number of the winning source |

## Verification
The bench builds the block with its defaults: 64 sources, 32-bit words and 4-bit priorities. With these values the address map holds two enable halves and eight priority words. A single run can therefore cover sources on both sides of the 31/32 boundary, the topmost source 63 with the largest priority 0xF, and a tie between sources 40 and 41. Expected read data and arbitration results come from a bench-side model of the enables, the priority words and the source levels. The checks cover priority-zero masking, pending sources that are not enabled, misaligned accesses, and the two-edge delay from a source change to the outputs.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // word index = byte address >> 3
   localparam int WIDX_CTRL_SET  = 0;
   localparam int WIDX_CTRL_CLR  = 1;
   localparam int WIDX_PRIO_BASE = 2;
   localparam int WIDX_SRC_LO    = 10;
   localparam int WIDX_SRC_HI    = 11;
   localparam int WIDX_REQ_LO    = 12;
   localparam int WIDX_REQ_HI    = 13;
   localparam int WIDX_EN_LO     = 14;
   localparam int WIDX_EN_HI     = 15;
   localparam int WIDX_DIS_LO    = 16;
   localparam int WIDX_DIS_HI    = 17;
   localparam int NUM_WIDX       = 18;
   localparam int CTRL_MODE_BIT  = 0;
endpackage

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
   parameter int NUM_SRC = 64,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         set_stb,
   input  logic [1:0]         clr_stb,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_SRC-1:0] en_o
);
   localparam int HALVES = NUM_SRC / DATA_W;

   generate
      for (genvar h = 0; h < HALVES; h++) begin : g_half
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               en_o[h*DATA_W +: DATA_W] <= '0;
            else if (set_stb[h])
               en_o[h*DATA_W +: DATA_W] <= en_o[h*DATA_W +: DATA_W] | wdata;
            else if (clr_stb[h])
               en_o[h*DATA_W +: DATA_W] <= en_o[h*DATA_W +: DATA_W] & ~wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/irq_prio_file.sv
module irq_prio_file #(
   parameter int NUM_PREG = 8,
   parameter int DATA_W   = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PREG-1:0]        wr_sel,
   input  logic [DATA_W-1:0]          wdata,
   output logic [NUM_PREG*DATA_W-1:0] prio_flat_o
);
   generate
      for (genvar k = 0; k < NUM_PREG; k++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               prio_flat_o[k*DATA_W +: DATA_W] <= '0;
            else if (wr_sel[k])
               prio_flat_o[k*DATA_W +: DATA_W] <= wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/irq_max_arb.sv
module irq_max_arb #(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4,
   parameter int ID_W    = 6
) (
   input  logic [NUM_SRC-1:0]        req,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
   output logic                      irq_o,
   output logic [PRIO_W-1:0]         lvl_o,
   output logic [ID_W-1:0]           id_o
);
   logic [PRIO_W-1:0] best_lvl;
   logic [ID_W-1:0]   best_id;

   // strict compare: lowest index keeps a tie, zero never wins
   always_comb begin
      best_lvl = '0;
      best_id  = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req[i] && (prio_flat[i*PRIO_W +: PRIO_W] > best_lvl)) begin
            best_lvl = prio_flat[i*PRIO_W +: PRIO_W];
            best_id  = ID_W'(i);
         end
      end
   end

   assign irq_o = (best_lvl != '0);
   assign lvl_o = best_lvl;
   assign id_o  = best_id;
endmodule

// File: rtl/irq_prio_regfile.sv
module irq_prio_regfile
   import irq_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int DATA_W  = 32,
   parameter int PRIO_W  = 4,
   parameter int ADDR_W  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   input  logic                       bus_wr,
   input  logic                       bus_rd,
   output logic [DATA_W-1:0]          bus_rdata,
   input  logic [NUM_SRC-1:0]         src_lvl_i,
   output logic                       irl_mode_o,
   output logic                       cpu_irq_o,
   output logic [PRIO_W-1:0]          cpu_lvl_o,
   output logic [$clog2(NUM_SRC)-1:0] cpu_id_o
);
   localparam int HALF     = DATA_W;
   localparam int FIELDS   = DATA_W / PRIO_W;
   localparam int NUM_PREG = NUM_SRC / FIELDS;
   localparam int ID_W     = $clog2(NUM_SRC);
   localparam int WIDX_W   = ADDR_W - 3;

   generate
      if (NUM_SRC != 2 * DATA_W) begin : g_bad_halves
         $error("NUM_SRC must fill exactly two data words");
      end
      if (DATA_W % PRIO_W != 0) begin : g_bad_fields
         $error("priority fields must pack evenly into a word");
      end
      if (WIDX_PRIO_BASE + NUM_PREG != WIDX_SRC_LO) begin : g_bad_map
         $error("priority words must end where source status begins");
      end
      if ((1 << WIDX_W) < NUM_WIDX) begin : g_bad_addr
         $error("address too narrow for register map");
      end
   endgenerate

   logic [WIDX_W-1:0]         widx;
   logic                      aligned;
   logic [NUM_WIDX-1:0]       wsel;
   logic                      mode_q;
   logic [NUM_SRC-1:0]        src_q;
   logic [NUM_SRC-1:0]        en_q;
   logic [NUM_SRC-1:0]        req;
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic [DATA_W-1:0]         rd_val;
   logic                      arb_irq;
   logic [PRIO_W-1:0]         arb_lvl;
   logic [ID_W-1:0]           arb_id;

   assign widx    = bus_addr[ADDR_W-1:3];
   assign aligned = (bus_addr[2:0] == 3'd0);

   always_comb begin
      for (int k = 0; k < NUM_WIDX; k++)
         wsel[k] = bus_wr && aligned && (widx == WIDX_W'(k));
   end

   // mode flag: separate set / clear words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= 1'b0;
      else if (wsel[WIDX_CTRL_SET] && bus_wdata[CTRL_MODE_BIT])
         mode_q <= 1'b1;
      else if (wsel[WIDX_CTRL_CLR] && bus_wdata[CTRL_MODE_BIT])
         mode_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src_lvl_i;
   end

   irq_enable_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb ({wsel[WIDX_EN_HI], wsel[WIDX_EN_LO]}),
      .clr_stb ({wsel[WIDX_DIS_HI], wsel[WIDX_DIS_LO]}),
      .wdata   (bus_wdata),
      .en_o    (en_q)
   );

   irq_prio_file #(.NUM_PREG(NUM_PREG), .DATA_W(DATA_W)) u_prio (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_sel      (wsel[WIDX_PRIO_BASE +: NUM_PREG]),
      .wdata       (bus_wdata),
      .prio_flat_o (prio_flat)
   );

   assign req = src_q & en_q;

   irq_max_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .req       (req),
      .prio_flat (prio_flat),
      .irq_o     (arb_irq),
      .lvl_o     (arb_lvl),
      .id_o      (arb_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_irq_o <= 1'b0;
         cpu_lvl_o <= '0;
         cpu_id_o  <= '0;
      end else begin
         cpu_irq_o <= arb_irq;
         cpu_lvl_o <= arb_lvl;
         cpu_id_o  <= arb_id;
      end
   end

   // read mux
   always_comb begin
      rd_val = '0;
      if (aligned) begin
         if ((int'(widx) >= WIDX_PRIO_BASE) && (int'(widx) < WIDX_PRIO_BASE + NUM_PREG))
            rd_val = prio_flat[(int'(widx) - WIDX_PRIO_BASE)*DATA_W +: DATA_W];
         else if (widx == WIDX_W'(WIDX_SRC_LO)) rd_val = src_q[HALF-1:0];
         else if (widx == WIDX_W'(WIDX_SRC_HI)) rd_val = src_q[NUM_SRC-1:HALF];
         else if (widx == WIDX_W'(WIDX_REQ_LO)) rd_val = req[HALF-1:0];
         else if (widx == WIDX_W'(WIDX_REQ_HI)) rd_val = req[NUM_SRC-1:HALF];
         else if (widx == WIDX_W'(WIDX_EN_LO))  rd_val = en_q[HALF-1:0];
         else if (widx == WIDX_W'(WIDX_EN_HI))  rd_val = en_q[NUM_SRC-1:HALF];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_val;
   end

   assign irl_mode_o = mode_q;
endmodule

// File: rtl/irq_prio_regfile_chk.sv
module irq_prio_regfile_chk
   import irq_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int DATA_W  = 32,
   parameter int PRIO_W  = 4,
   parameter int ADDR_W  = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [DATA_W-1:0]          bus_wdata,
   input logic                       bus_wr,
   input logic [NUM_SRC-1:0]         en_vec,
   input logic                       irl_mode_o,
   input logic                       cpu_irq_o,
   input logic [PRIO_W-1:0]          cpu_lvl_o,
   input logic [$clog2(NUM_SRC)-1:0] cpu_id_o
);
   localparam int HALF   = DATA_W;
   localparam int WIDX_W = ADDR_W - 3;

   logic [NUM_SRC-1:0] en_d;
   logic               hit_en_lo, hit_dis_lo, hit_dis_hi, hit_ctrl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_d <= '0;
      else        en_d <= en_vec;
   end

   assign hit_en_lo  = bus_wr && (bus_addr == ADDR_W'(WIDX_EN_LO  << 3));
   assign hit_dis_lo = bus_wr && (bus_addr == ADDR_W'(WIDX_DIS_LO << 3));
   assign hit_dis_hi = bus_wr && (bus_addr == ADDR_W'(WIDX_DIS_HI << 3));
   assign hit_ctrl   = bus_wr && ((bus_addr == ADDR_W'(WIDX_CTRL_SET << 3)) ||
                                  (bus_addr == ADDR_W'(WIDX_CTRL_CLR << 3)));

   a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_ctrl |=> $stable(irl_mode_o));

   a_r4_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
      hit_en_lo |=> ((en_vec[HALF-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

   a_r5_clr_lo: assert property (@(posedge clk) disable iff (!rst_n)
      hit_dis_lo |=> ((en_vec[HALF-1:0] & $past(bus_wdata)) == '0));

   a_r5_clr_hi: assert property (@(posedge clk) disable iff (!rst_n)
      hit_dis_hi |=> ((en_vec[NUM_SRC-1:HALF] & $past(bus_wdata)) == '0));

   a_r6_grant_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq_o |-> en_d[cpu_id_o]);

   a_r7_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq_o |-> (cpu_lvl_o != '0));

   a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_irq_o |-> (cpu_lvl_o == '0 && cpu_id_o == '0));
endmodule

bind irq_prio_regfile irq_prio_regfile_chk #(
   .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_wr     (bus_wr),
   .en_vec     (en_q),
   .irl_mode_o (irl_mode_o),
   .cpu_irq_o  (cpu_irq_o),
   .cpu_lvl_o  (cpu_lvl_o),
   .cpu_id_o   (cpu_id_o)
);

// File: tb/irq_prio_regfile_tb_top.sv
`timescale 1ns/1ps
module irq_prio_regfile_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [63:0] src_lvl_i = '0;
   logic        irl_mode_o;
   logic        cpu_irq_o;
   logic [3:0]  cpu_lvl_o;
   logic [5:0]  cpu_id_o;

   always #2 clk = ~clk;   // 250 MHz

   irq_prio_regfile dut_i (.*);

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // bench-side model
   logic [63:0] en_m = '0;
   logic [3:0]  prio_m [64];

   // scoreboard for read data
   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        rd_fire = 1'b0;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) rd_fire <= bus_rd;

   always @(negedge clk) begin
      if (rd_fire && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, bus_rdata, e);
      end
   end

   task automatic wr(logic [7:0] a, logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
      bus_addr = a; bus_rd = 1'b1;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic set_prio_word(int k, logic [31:0] d);
      wr(8'(8'h10 + 8*k), d);
      for (int f = 0; f < 8; f++) prio_m[k*8+f] = d[f*4 +: 4];
   endtask

   task automatic check_cpu(string tag);
      logic [3:0] bl;
      logic [5:0] bi;
      logic [63:0] rq;
      bl = '0; bi = '0;
      repeat (3) @(negedge clk);
      rq = src_lvl_i & en_m;
      for (int i = 0; i < 64; i++)
         if (rq[i] && prio_m[i] > bl) begin bl = prio_m[i]; bi = 6'(i); end
      check({tag, " irq"}, {31'd0, cpu_irq_o}, {31'd0, bl != 0});
      check({tag, " lvl"}, {28'd0, cpu_lvl_o}, {28'd0, bl});
      check({tag, " id"},  {26'd0, cpu_id_o},  {26'd0, bi});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 64; i++) prio_m[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 mode", {31'd0, irl_mode_o}, 32'd0);
      check_cpu("R1");
      rd(8'h70, 32'h0, "R1 en lo");
      rd(8'h78, 32'h0, "R1 en hi");
      rd(8'h10, 32'h0, "R1 prio0");
      rd(8'h48, 32'h0, "R1 prio7");

      // R2 mode flag
      wr(8'h00, 32'h0);
      check("R2 set zero no effect", {31'd0, irl_mode_o}, 32'd0);
      wr(8'h00, 32'h1);
      check("R2 set", {31'd0, irl_mode_o}, 32'd1);
      wr(8'h08, 32'hFFFF_FFFE);
      check("R2 clr zero bit0", {31'd0, irl_mode_o}, 32'd1);
      wr(8'h08, 32'h1);
      check("R2 clr", {31'd0, irl_mode_o}, 32'd0);

      // R9 zero-reading addresses
      rd(8'h00, 32'h0, "R9 ctrl set reads 0");
      rd(8'h08, 32'h0, "R9 ctrl clr reads 0");

      // R3 priority words
      set_prio_word(0, 32'h0030_0000);   // source 5 -> 3, source 2 -> 0
      set_prio_word(3, 32'h1234_5678);
      set_prio_word(5, 32'h0000_0077);   // sources 40,41 -> 7
      set_prio_word(7, 32'hF000_0000);   // source 63 -> F
      rd(8'h10, 32'h0030_0000, "R3 prio0");
      rd(8'h28, 32'h1234_5678, "R3 prio3");
      rd(8'h38, 32'h0000_0077, "R3 prio5");
      rd(8'h48, 32'hF000_0000, "R3 prio7");

      // R4 enable set
      wr(8'h70, 32'h0000_0024); en_m[31:0] |= 32'h24;
      wr(8'h70, 32'h0);
      rd(8'h70, 32'h0000_0024, "R4 en lo");
      wr(8'h78, 32'h0000_0300); en_m[63:32] |= 32'h300;
      rd(8'h78, 32'h0000_0300, "R4 en hi");
      wr(8'h71, 32'hFFFF_FFFF);  // misaligned: ignored
      rd(8'h70, 32'h0000_0024, "R4 misaligned ignored");

      // R6 enabled but not pending
      check_cpu("R6 none pending");

      // R7 priority zero source
      src_lvl_i[2] = 1'b1;
      check_cpu("R7 prio zero");
      rd(8'h50, 32'h0000_0004, "R6 src lo");
      rd(8'h60, 32'h0000_0004, "R6 req lo");

      // R8 single winner, then tie
      src_lvl_i[5] = 1'b1;
      check_cpu("R8 single");
      src_lvl_i[41] = 1'b1; src_lvl_i[40] = 1'b1;
      check_cpu("R8 tie low index");

      // R6 pending not enabled
      src_lvl_i[63] = 1'b1;
      check_cpu("R6 masked pending");
      rd(8'h58, 32'h8000_0300, "R6 src hi");
      rd(8'h68, 32'h0000_0300, "R6 req hi");
      wr(8'h50, 32'hFFFF_FFFF);
      rd(8'h50, 32'h0000_0024, "R6 status write ignored");

      wr(8'h78, 32'h8000_0000); en_m[63] = 1'b1;
      check_cpu("R8 top source");

      // R10 latency
      src_lvl_i[63] = 1'b0;
      @(negedge clk);
      check("R10 one edge old", {28'd0, cpu_lvl_o}, 32'hF);
      @(negedge clk);
      check("R10 two edges new", {28'd0, cpu_lvl_o}, 32'h7);
      check("R10 two edges id", {26'd0, cpu_id_o}, 32'd40);

      // R9 disable addresses read zero
      rd(8'h80, 32'h0, "R9 dis lo reads 0");
      rd(8'h88, 32'h0, "R9 dis hi reads 0");

      // R5 partial disable then full
      wr(8'h88, 32'h0000_0100); en_m[40] = 1'b0;
      check_cpu("R5 partial disable");
      wr(8'h80, 32'hFFFF_FFFF);
      wr(8'h88, 32'hFFFF_FFFF);
      en_m = '0;
      rd(8'h70, 32'h0, "R5 en lo cleared");
      rd(8'h78, 32'h0, "R5 en hi cleared");
      check_cpu("R5 all masked");

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule